// File: doc/BRIEF.md
# Floppy head positioning sequencer

This block carries out the head-movement commands of a floppy disk controller. An 8-bit command byte is accepted while the block is idle. It is decoded as one of five commands: return to track zero, seek to a target track, step in the last direction, step toward the centre, or step toward the edge. The block then drives single-clock step pulses and a direction level toward the drive. The time between pulses comes from a rate table selected by the command, the test pin and the clock-rate select.

The block holds the track register. A seek compares that register against the target byte, which is captured when the command is accepted. A return to track zero runs until the track-zero input is seen, or until a fixed number of pulses has been issued without it. A busy flag covers the whole command and a completion flag is raised at its end. The head-load and verify request bits of the command are reported in status. Reading the ID field to confirm the track is left to other logic.

Top module: `fdc_head_pos`

## Requirements
- R1: The command byte is decoded on bits 7..4: 0000 return to zero, 0001 seek, 001x step, 010x step-in, 011x step-out. A byte with bit 7 set, or any byte written while busy, is ignored: no pulse, no change of track, busy or intrq.
- R2: For step, step-in and step-out, bit 4 set makes the track register follow each pulse (+1 inward, -1 outward). Bit 4 clear leaves the track register unchanged.
- R3: Command bit 3 (head load) drives `head_load` and status bit 1. Command bit 2 (verify request) drives status bit 3. Both are held from acceptance until the next accepted command.
- R4: The pulse period P is a number of time units times UNIT_CYCLES clocks. With `test_mode`=1 and `clk_fast`=1, rate bits 1..0 of 00/01/10/11 give 30/60/100/150 units. With `test_mode`=0 the period is 2 units whatever the rate bits are. With `clk_fast`=0 every value is doubled. Consecutive pulses of one command are P+2 clocks apart.
- R5: Return to zero pulses outward (dirc=0) until `trk0` is high at a check, then clears the track register to 0. If `trk0` is already high, no pulse is sent.
- R6: If `trk0` has not appeared after MAX_PULSES (256) pulses, return to zero ends and sets status bit 4. The track register is kept. Status bit 4 is cleared by the next accepted command.
- R7: Seek captures `data_reg` at acceptance. It pulses toward it, changing the track register by 1 with each pulse, until the two are equal. With equal values it ends without a pulse.
- R8: `dirc`=1 means toward the centre and `dirc`=0 toward the edge. A plain step reuses the direction of the previous pulse.
- R9: Status bit 0 (busy) goes high, and `intrq` goes low, on the clock after acceptance. The command ends with busy low and `intrq` high: 1 clock after acceptance for a seek or return to zero with no pulse, K*(P+2)+1 clocks for one with K pulses, and P+2 clocks for a step.
- R10: `step` is high for exactly one clock. The first pulse comes 2 clocks after acceptance. `dirc` holds its new value for at least one clock before each pulse.
- R11: Status bit 2 follows `trk0` at all times. Status bits 7..5 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one clock |
| cmd | input | 8 | Command byte |
| data_reg | input | 8 | Seek target track |
| trk0 | input | 1 | Head at track zero (active high) |
| test_mode | input | 1 | 1 selects the rate table, 0 the fixed short period |
| clk_fast | input | 1 | 1 for the faster clock, 0 doubles every period |
| step | output | 1 | Step pulse toward the drive |
| dirc | output | 1 | Direction: 1 inward, 0 outward |
| track | output | 8 | Track register |
| head_load | output | 1 | Head-load request of the current command |
| status | output | 8 | {000, gave-up, verify, trk0, head-load, busy} |
| intrq | output | 1 | Command complete flag |

## Verification
Busy and intrq change on the clock after acceptance. The first pulse comes 2 clocks after acceptance and each further pulse P+2 clocks after the previous one. The end of a command is due at K*(P+2)+1 clocks for a return to zero or a seek, and at P+2 clocks for a step. For each command the bench works out these cycle numbers from the requirements and queues one expected item per pulse, holding the direction, the track value and the gap. A monitor sampling at the falling edge matches every pulse against the queue, with the exact gap measured from a free-running cycle count. The end time of the command is checked against the same count, and any pulse that arrives with the queue empty is an error.

// File: rtl/hpos_pkg.sv
package hpos_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_RESTORE,
        K_SEEK,
        K_STEP,
        K_STEPIN,
        K_STEPOUT
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_PULSE,
        S_WAIT
    } state_e;

    typedef struct packed {
        kind_e      kind;
        logic       upd;
        logic       hload;
        logic       verify;
        logic [1:0] rate;
    } cmd_t;

    // step period in 100 us units for the fast clock; doubled for the slow clock
    function automatic logic [8:0] rate_units(logic [1:0] r, logic test, logic fast);
        logic [8:0] u;
        if (test) begin
            case (r)
                2'd0:    u = 9'd30;
                2'd1:    u = 9'd60;
                2'd2:    u = 9'd100;
                default: u = 9'd150;
            endcase
        end else begin
            u = 9'd2;
        end
        if (!fast) u = u << 1;
        return u;
    endfunction

endpackage

// File: rtl/hpos_decode.sv
module hpos_decode
    import hpos_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       word
);
    always_comb begin
        word.upd    = cmd_byte[4];
        word.hload  = cmd_byte[3];
        word.verify = cmd_byte[2];
        word.rate   = cmd_byte[1:0];
        casez (cmd_byte[7:4])
            4'b0000: word.kind = K_RESTORE;
            4'b0001: word.kind = K_SEEK;
            4'b001?: word.kind = K_STEP;
            4'b010?: word.kind = K_STEPIN;
            4'b011?: word.kind = K_STEPOUT;
            default: word.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/hpos_rate.sv
module hpos_rate
    import hpos_pkg::*;
#(
    parameter int UNIT_CYCLES = 100,
    parameter int CNT_W       = 15
) (
    input  logic [1:0]       rate,
    input  logic             test_mode,
    input  logic             clk_fast,
    output logic [CNT_W-1:0] reload
);
    logic [8:0]       units;
    logic [CNT_W-1:0] cycles;

    always_comb begin
        units  = rate_units(rate, test_mode, clk_fast);
        cycles = CNT_W'(units) * CNT_W'(UNIT_CYCLES);
        reload = cycles - CNT_W'(1);
    end
endmodule

// File: rtl/hpos_timer.sv
module hpos_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fdc_head_pos.sv
module fdc_head_pos
    import hpos_pkg::*;
#(
    parameter int UNIT_CYCLES = 100,
    parameter int MAX_PULSES  = 256,
    parameter int TRK_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd,
    input  logic [TRK_W-1:0] data_reg,
    input  logic             trk0,
    input  logic             test_mode,
    input  logic             clk_fast,
    output logic             step,
    output logic             dirc,
    output logic [TRK_W-1:0] track,
    output logic             head_load,
    output logic [7:0]       status,
    output logic             intrq
);
    localparam int CNT_W = $clog2(300 * UNIT_CYCLES);
    localparam int PCW   = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        state_e           state;
        cmd_t             cw;
        logic [TRK_W-1:0] target;
        logic [TRK_W-1:0] track;
        logic             dir;
        logic             step;
        logic             busy;
        logic             intrq;
        logic             gave_up;
        logic [PCW-1:0]   pulses;
    } regs_t;

    regs_t r_d, r_q;

    cmd_t             dec;
    logic [CNT_W-1:0] reload;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_expired;

    hpos_decode u_dec (
        .cmd_byte (cmd),
        .word     (dec)
    );

    hpos_rate #(
        .UNIT_CYCLES (UNIT_CYCLES),
        .CNT_W       (CNT_W)
    ) u_rate (
        .rate      (r_q.cw.rate),
        .test_mode (test_mode),
        .clk_fast  (clk_fast),
        .reload    (reload)
    );

    hpos_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (reload),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    logic moves_track;
    logic repeats;

    always_comb begin
        r_d      = r_q;
        r_d.step = 1'b0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;

        moves_track = (r_q.cw.kind == K_SEEK) ||
                      (r_q.cw.upd && (r_q.cw.kind == K_STEP ||
                                      r_q.cw.kind == K_STEPIN ||
                                      r_q.cw.kind == K_STEPOUT));
        repeats     = (r_q.cw.kind == K_RESTORE) || (r_q.cw.kind == K_SEEK);

        case (r_q.state)
            S_IDLE: begin
                if (cmd_we && dec.kind != K_NONE) begin
                    r_d.cw      = dec;
                    r_d.target  = data_reg;
                    r_d.busy    = 1'b1;
                    r_d.intrq   = 1'b0;
                    r_d.gave_up = 1'b0;
                    r_d.pulses  = '0;
                    r_d.state   = S_CHECK;
                end
            end

            S_CHECK: begin
                case (r_q.cw.kind)
                    K_RESTORE: begin
                        if (trk0) begin
                            r_d.track = '0;
                            r_d.busy  = 1'b0;
                            r_d.intrq = 1'b1;
                            r_d.state = S_IDLE;
                        end else if (r_q.pulses == PCW'(MAX_PULSES)) begin
                            r_d.gave_up = 1'b1;
                            r_d.busy    = 1'b0;
                            r_d.intrq   = 1'b1;
                            r_d.state   = S_IDLE;
                        end else begin
                            r_d.dir   = 1'b0;
                            r_d.state = S_PULSE;
                        end
                    end
                    K_SEEK: begin
                        if (r_q.track == r_q.target) begin
                            r_d.busy  = 1'b0;
                            r_d.intrq = 1'b1;
                            r_d.state = S_IDLE;
                        end else begin
                            r_d.dir   = (r_q.target > r_q.track);
                            r_d.state = S_PULSE;
                        end
                    end
                    K_STEPIN: begin
                        r_d.dir   = 1'b1;
                        r_d.state = S_PULSE;
                    end
                    K_STEPOUT: begin
                        r_d.dir   = 1'b0;
                        r_d.state = S_PULSE;
                    end
                    default: begin
                        r_d.state = S_PULSE;
                    end
                endcase
            end

            S_PULSE: begin
                r_d.step   = 1'b1;
                tmr_load   = 1'b1;
                r_d.pulses = r_q.pulses + PCW'(1);
                if (moves_track) begin
                    if (r_q.dir) r_d.track = r_q.track + TRK_W'(1);
                    else         r_d.track = r_q.track - TRK_W'(1);
                end
                r_d.state  = S_WAIT;
            end

            S_WAIT: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    if (repeats) begin
                        r_d.state = S_CHECK;
                    end else begin
                        r_d.busy  = 1'b0;
                        r_d.intrq = 1'b1;
                        r_d.state = S_IDLE;
                    end
                end
            end

            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= S_IDLE;
            r_q.cw      <= '{kind: K_NONE, upd: 1'b0, hload: 1'b0, verify: 1'b0, rate: 2'b00};
            r_q.target  <= '0;
            r_q.track   <= '0;
            r_q.dir     <= 1'b0;
            r_q.step    <= 1'b0;
            r_q.busy    <= 1'b0;
            r_q.intrq   <= 1'b0;
            r_q.gave_up <= 1'b0;
            r_q.pulses  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign step      = r_q.step;
    assign dirc      = r_q.dir;
    assign track     = r_q.track;
    assign head_load = r_q.cw.hload;
    assign intrq     = r_q.intrq;
    assign status    = {3'b000, r_q.gave_up, r_q.cw.verify, trk0, r_q.cw.hload, r_q.busy};

endmodule

// File: rtl/hpos_chk.sv
module hpos_chk #(
    parameter int MAX_PULSES = 256,
    parameter int TRK_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic             step,
    input logic             dirc,
    input logic [TRK_W-1:0] track,
    input logic [7:0]       status,
    input logic             intrq
);
    localparam int SCW = $clog2(MAX_PULSES + 2);
    logic [SCW-1:0] steps_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !status[0]) steps_q <= '0;
        else if (step)            steps_q <= steps_q + SCW'(1);
    end

    // R10: pulse is one clock wide
    assert_step_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

    // R10: direction was already in place the clock before the pulse
    assert_dir_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step) |-> $stable(dirc));

    // R9: pulses only inside a command
    assert_step_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> status[0]);

    // R9: busy and completion are exclusive
    assert_busy_intrq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[0] && intrq));

    // R1: a command starts only from a write strobe
    assert_start_from_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(cmd_we));

    // R2: track moves only with a pulse or at the end of a command
    assert_track_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(track) |-> (step || $fell(status[0])));

    // R6: never more pulses than the give-up limit in one command
    assert_pulse_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        steps_q <= SCW'(MAX_PULSES));

endmodule

bind fdc_head_pos hpos_chk #(
    .MAX_PULSES (MAX_PULSES),
    .TRK_W      (TRK_W)
) u_hpos_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_we (cmd_we),
    .step   (step),
    .dirc   (dirc),
    .track  (track),
    .status (status),
    .intrq  (intrq)
);

// File: tb/tb_fdc_head_pos.sv
module tb_fdc_head_pos;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic [7:0] data_reg = 8'h00;
    logic       trk0;
    logic       test_mode = 1'b0;
    logic       clk_fast = 1'b1;
    logic       step, dirc, head_load, intrq;
    logic [7:0] track, status;

    int  pos = 3;
    bit  broken = 1'b0;
    assign trk0 = (pos == 0) && !broken;

    always #2 clk = ~clk;

    fdc_head_pos #(.UNIT_CYCLES(1)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd), .data_reg(data_reg),
        .trk0(trk0), .test_mode(test_mode), .clk_fast(clk_fast),
        .step(step), .dirc(dirc), .track(track), .head_load(head_load),
        .status(status), .intrq(intrq)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    longint t_last = 0;
    bit     done_flag = 0;

    typedef struct {
        logic       dir;
        logic [7:0] trk;
        int         gap;
        string      tag;
    } item_t;
    item_t exp_q[$];

    logic [7:0] mtrack = 8'd0;
    logic       mdir = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: every pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && step) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected step pulse", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(dirc == it.dir, "R8", "dirc at pulse", dirc, it.dir);
                chk(track == it.trk, it.tag, "track after pulse", track, it.trk);
                chk((cyc - t_last) == it.gap, "R4", "pulse gap", cyc - t_last, it.gap);
            end
            t_last = cyc;
            if (dirc) pos = pos + 1;
            else if (pos > 0) pos = pos - 1;
        end
    end

    function automatic int period(input logic [1:0] r);
        int u;
        if (test_mode) begin
            case (r)
                2'd0: u = 30;
                2'd1: u = 60;
                2'd2: u = 100;
                default: u = 150;
            endcase
        end else u = 2;
        if (!clk_fast) u = u * 2;
        return u;
    endfunction

    task automatic push(input logic d, input logic [7:0] t, input int idx, input int p,
                        input string tag);
        item_t it;
        it.dir = d;
        it.trk = t;
        it.gap = (idx == 0) ? 2 : p + 2;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic run_cmd(input logic [7:0] c, input logic [7:0] d, input bit intrude);
        int     p, k, n;
        logic   dir;
        bit     give;
        longint t_issue, exp_done;
        string  tag;
        p = period(c[1:0]);
        give = 0;
        k = 0;
        casez (c[7:4])
            4'b0000: begin
                tag = broken ? "R6" : "R5";
                k = broken ? 256 : pos;
                give = broken;
                for (int i = 0; i < k; i++) push(1'b0, mtrack, i, p, tag);
                if (k > 0) mdir = 1'b0;
                if (!broken) mtrack = 8'd0;
                exp_done = k * (p + 2) + 1;
            end
            4'b0001: begin
                tag = "R7";
                dir = (d > mtrack);
                k = dir ? int'(d - mtrack) : int'(mtrack - d);
                for (int i = 0; i < k; i++) begin
                    mtrack = dir ? mtrack + 8'd1 : mtrack - 8'd1;
                    push(dir, mtrack, i, p, tag);
                end
                if (k > 0) mdir = dir;
                exp_done = k * (p + 2) + 1;
            end
            default: begin
                tag = "R2";
                if (c[6:5] == 2'b01) dir = mdir;
                else dir = (c[6:5] == 2'b10);
                if (c[4]) mtrack = dir ? mtrack + 8'd1 : mtrack - 8'd1;
                push(dir, mtrack, 0, p, tag);
                mdir = dir;
                exp_done = p + 2;
            end
        endcase

        @(negedge clk);
        cmd = c; data_reg = d; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        t_issue = cyc;
        t_last = cyc;
        chk(status[0] == 1'b1, "R9", "busy after accept", status[0], 1);
        chk(intrq == 1'b0, "R9", "intrq cleared on accept", intrq, 0);
        if (intrude) begin
            repeat (5) @(negedge clk);
            cmd = 8'h50; cmd_we = 1'b1;
            @(negedge clk);
            cmd_we = 1'b0;
        end
        n = 0;
        while (status[0] && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk((cyc - t_issue) == exp_done, "R9", "completion time", cyc - t_issue, exp_done);
        chk(exp_q.size() == 0, tag, "pulses missing", exp_q.size(), 0);
        exp_q.delete();
        chk(intrq == 1'b1, "R9", "intrq at end", intrq, 1);
        chk(track == mtrack, tag, "track at end", track, mtrack);
        chk(head_load == c[3], "R3", "head_load", head_load, c[3]);
        chk(status[1] == c[3], "R3", "status head-load bit", status[1], c[3]);
        chk(status[3] == c[2], "R3", "status verify bit", status[3], c[2]);
        chk(status[4] == give, "R6", "status gave-up bit", status[4], give);
        chk(status[7:5] == 3'b000, "R11", "status top bits", status[7:5], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step == 1'b0, "R10", "reset step", step, 0);
        chk(status[0] == 1'b0, "R9", "reset busy", status[0], 0);
        chk(intrq == 1'b0, "R9", "reset intrq", intrq, 0);
        chk(track == 8'd0, "R2", "reset track", track, 0);
        chk(status[2] == trk0, "R11", "trk0 mirror at reset", status[2], trk0);

        run_cmd(8'h08, 8'h00, 0);          // return to zero from pos 3, head load
        chk(status[2] == 1'b1, "R11", "trk0 mirror after return", status[2], 1);
        run_cmd(8'h10, 8'd5, 0);           // seek in to 5
        run_cmd(8'h14, 8'd2, 0);           // seek out to 2 with verify
        run_cmd(8'h10, 8'd2, 0);           // seek equal, no pulse
        run_cmd(8'h50, 8'h00, 0);          // step-in, update
        run_cmd(8'h30, 8'h00, 0);          // step, sticky inward, update
        run_cmd(8'h60, 8'h00, 0);          // step-out, no update
        run_cmd(8'h20, 8'h00, 0);          // step, sticky outward, no update
        run_cmd(8'h21, 8'h00, 0);          // rate bits ignored with test_mode low

        test_mode = 1'b1;
        for (int r = 0; r < 4; r++) run_cmd(8'h40 | 8'(r), 8'h00, 0);  // R4 table
        clk_fast = 1'b0;
        run_cmd(8'h43, 8'h00, 0);          // doubled slow entry
        test_mode = 1'b0;
        run_cmd(8'h40, 8'h00, 0);          // doubled short period
        clk_fast = 1'b1;

        test_mode = 1'b1;
        run_cmd(8'h00, 8'h00, 1);          // return to zero, write while busy ignored
        test_mode = 1'b0;

        @(negedge clk);
        cmd = 8'h80; cmd_we = 1'b1;        // R1: outside this group
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (20) @(negedge clk);
        chk(status[0] == 1'b0, "R1", "bit7 command busy", status[0], 0);
        chk(intrq == 1'b1, "R1", "bit7 command intrq", intrq, 1);
        chk(track == mtrack, "R1", "bit7 command track", track, mtrack);

        run_cmd(8'h10, 8'd9, 0);           // seek to 9
        broken = 1'b1;
        @(negedge clk);
        chk(status[2] == 1'b0, "R11", "trk0 mirror low", status[2], 0);
        run_cmd(8'h04, 8'h00, 0);          // R6 give up after 256 pulses
        broken = 1'b0;
        @(negedge clk);
        chk(status[2] == 1'b1, "R11", "trk0 mirror high", status[2], 1);
        run_cmd(8'h00, 8'h00, 0);          // R5 no pulse when trk0 already high

        finish_run();
    end

endmodule